// File: doc/BRIEF.md
# Row-Interleaved Single-Adder Accumulator

This block reduces per-row dot products of a sparse matrix-vector product with a single integer adder whose pipeline is `L` stages deep. A front end delivers one partial sum per cycle, each covering up to `K` nonzeros of one row. The stream arrives already rescheduled, so that consecutive words belong to consecutive adder slots. The block keeps up to `L` rows in flight, one per slot. Every adder output is routed back into its own slot until that row has received all of its partial sums. The finished sum then leaves with its row index.

Before a run, software writes the nonzero count of every row into a local table and sets the row total. A `start` pulse arms the controller. Consumption begins once the input FIFO reports data. A slot pointer visits the slots in a fixed cycle. A slot that has finished its row is given the lowest-numbered row not yet assigned. A per-issue tag (valid, last, row) travels beside the adder stages, so the completion decision is made from the tag that comes out with the sum. When the FIFO runs dry while a slot needs data, the whole pipeline holds. When no rows are left, idle slots let the pipeline run on until every row has been written, and then `done` pulses.

Top module: `row_interleave_acc`

## Requirements
- R1: Each written `outSum` equals the sum of all partial sums consumed for that row.
- R2: A row with table count c (c ≥ 1) consumes exactly ceil(c/K) words from the input stream, where K defaults to 4.
- R3: `inRead` is never high while `inEmpty` is high, and no word is read before a `start` pulse.
- R4: The slot pointer steps 0,1,…,L-1 and wraps. The first visits after `start` assign rows 0,1,2,… in ascending order. A slot whose row has no words left is given the next unassigned row on its following visit, so with more than L rows every row is still summed correctly.
- R5: A row that needs fewer passes can be written before an earlier-numbered row that needs more passes.
- R6: Each row of a run is written exactly once, with `outRow` equal to its index.
- R7: While the current slot needs a word and `inEmpty` is high, slot pointer and adder pipeline hold, so input stalls at any point leave every result unchanged.
- R8: A slot without an assigned row contributes no write. A run of N rows produces exactly N writes.
- R9: After the last word has been consumed, the pipeline keeps running until all rows are written, and no further words are read even if `inEmpty` is low.
- R10: `done` is high for exactly one cycle, the cycle after the final row's write.
- R11: After reset, `outWrite`, `done` and `inRead` are low until a `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| numRows | input | RW+1 | Row total of the run, sampled on `start` |
| loadEn | input | 1 | Write strobe for the count table |
| loadAddr | input | RW | Row index to load |
| loadCount | input | CW | Nonzero count of that row (≥ 1) |
| inEmpty | input | 1 | Input FIFO has no word |
| inData | input | W | Partial sum at the FIFO head |
| inRead | output | 1 | Pop the FIFO head this cycle |
| outWrite | output | 1 | A finished row sum is valid |
| outRow | output | RW | Index of the finished row |
| outSum | output | W | Finished row sum |
| done | output | 1 | One-cycle pulse after the last row is written |

## Verification
A slot controller with a wrong row or count field shows up as a sum that includes a word from another row, or misses one. It can also show up as a row written twice or never. Either is visible at `outWrite` within about L cycles of the faulty pass, which is one trip through the adder. A misaligned completion tag makes a sum leave early or loop past its last pass. A broken hold on an empty FIFO shifts every later word to the wrong slot, which corrupts all rows still in flight. The bench therefore compares every row sum and write count. It also compares the order of the first write, the `done` timing and the read behaviour with and without input stalls.

// File: rtl/rowacc_pkg.sv
package rowacc_pkg;
  // Strobes from the slot controller to the adder datapath
  typedef struct packed {
    logic advance;  // slot pointer and adder stages move this cycle
    logic issue;    // a word from the FIFO enters the adder for the current slot
    logic last;     // that word is the final one of its row
  } ctrlStb_t;
endpackage

// File: rtl/rowacc_ctrl.sv
module rowacc_ctrl
  import rowacc_pkg::*;
#(
  parameter int L        = 10,
  parameter int K        = 4,
  parameter int CW       = 16,
  parameter int MAX_ROWS = 64,
  localparam int RW = $clog2(MAX_ROWS),
  localparam int PW = $clog2(L)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [RW:0]   numRows,
  input  logic          loadEn,
  input  logic [RW-1:0] loadAddr,
  input  logic [CW-1:0] loadCount,
  input  logic          inEmpty,
  input  logic          outWrite,
  output logic          inRead,
  output ctrlStb_t      stb,
  output logic [RW-1:0] issueRow,
  output logic          done
);
  localparam logic [CW-1:0] KC   = CW'(K);
  localparam logic [PW-1:0] LAST = PW'(L - 1);

  logic [CW-1:0] countTab [MAX_ROWS];
  logic [CW-1:0] slotRem  [L];
  logic [RW-1:0] slotRow  [L];
  logic [PW-1:0] ptr;
  logic [RW:0]   nextRow, numRowsQ, writes;
  logic          running;

  logic [CW-1:0] curRem, srcCount, newRem;
  logic          cont, rowsLeft, needIn, take;

  always_comb begin
    curRem   = slotRem[ptr];
    cont     = curRem != '0;
    rowsLeft = nextRow < numRowsQ;
    needIn   = running && (cont || rowsLeft);
    take     = needIn && !inEmpty;
    srcCount = cont ? curRem : countTab[nextRow[RW-1:0]];
    newRem   = (srcCount > KC) ? srcCount - KC : '0;
    issueRow = cont ? slotRow[ptr] : nextRow[RW-1:0];
    inRead      = take;
    stb.advance = !(needIn && inEmpty);
    stb.issue   = take;
    stb.last    = srcCount <= KC;
  end

  always_ff @(posedge clk) begin
    if (loadEn) countTab[loadAddr] <= loadCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      running  <= 1'b0;
      nextRow  <= '0;
      numRowsQ <= '0;
      writes   <= '0;
      done     <= 1'b0;
      for (int i = 0; i < L; i++) begin
        slotRem[i] <= '0;
        slotRow[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (start) begin
        running  <= 1'b1;
        numRowsQ <= numRows;
        nextRow  <= '0;
        writes   <= '0;
        ptr      <= '0;
        for (int i = 0; i < L; i++) slotRem[i] <= '0;
      end else begin
        if (stb.advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        if (take) begin
          slotRem[ptr] <= newRem;
          if (!cont) begin
            slotRow[ptr] <= nextRow[RW-1:0];
            nextRow      <= nextRow + 1'b1;
          end
        end
        if (outWrite) begin
          writes <= writes + 1'b1;
          if ((writes + 1'b1) == numRowsQ) begin
            done    <= 1'b1;
            running <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rowacc_dp.sv
module rowacc_dp
  import rowacc_pkg::*;
#(
  parameter int L  = 10,
  parameter int W  = 32,
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStb_t      stb,
  input  logic [RW-1:0] issueRow,
  input  logic [W-1:0]  inData,
  output logic          outWrite,
  output logic [RW-1:0] outRow,
  output logic [W-1:0]  outSum
);
  logic [W-1:0]  sumPipe  [L];
  logic [RW-1:0] rowPipe  [L];
  logic          vPipe    [L];
  logic          lastPipe [L];

  logic [W-1:0] fbVal, stageIn;
  logic         tailOpen;

  always_comb begin
    tailOpen = vPipe[L-1] && !lastPipe[L-1];
    fbVal    = tailOpen ? sumPipe[L-1] : '0;
    stageIn  = (stb.issue ? inData : '0) + fbVal;
    outWrite = stb.advance && vPipe[L-1] && lastPipe[L-1];
    outRow   = rowPipe[L-1];
    outSum   = sumPipe[L-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < L; i++) begin
        sumPipe[i]  <= '0;
        rowPipe[i]  <= '0;
        vPipe[i]    <= 1'b0;
        lastPipe[i] <= 1'b0;
      end
    end else if (stb.advance) begin
      sumPipe[0]  <= stageIn;
      rowPipe[0]  <= issueRow;
      vPipe[0]    <= stb.issue;
      lastPipe[0] <= stb.last;
      for (int i = 1; i < L; i++) begin
        sumPipe[i]  <= sumPipe[i-1];
        rowPipe[i]  <= rowPipe[i-1];
        vPipe[i]    <= vPipe[i-1];
        lastPipe[i] <= lastPipe[i-1];
      end
    end
  end
endmodule

// File: rtl/row_interleave_acc.sv
module row_interleave_acc
  import rowacc_pkg::*;
#(
  parameter int L        = 10,
  parameter int K        = 4,
  parameter int W        = 32,
  parameter int CW       = 16,
  parameter int MAX_ROWS = 64,
  localparam int RW = $clog2(MAX_ROWS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [RW:0]   numRows,
  input  logic          loadEn,
  input  logic [RW-1:0] loadAddr,
  input  logic [CW-1:0] loadCount,
  input  logic          inEmpty,
  input  logic [W-1:0]  inData,
  output logic          inRead,
  output logic          outWrite,
  output logic [RW-1:0] outRow,
  output logic [W-1:0]  outSum,
  output logic          done
);
  ctrlStb_t      stb;
  logic [RW-1:0] issueRow;

  rowacc_ctrl #(.L(L), .K(K), .CW(CW), .MAX_ROWS(MAX_ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .numRows(numRows),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadCount(loadCount),
    .inEmpty(inEmpty), .outWrite(outWrite), .inRead(inRead),
    .stb(stb), .issueRow(issueRow), .done(done)
  );

  rowacc_dp #(.L(L), .W(W), .RW(RW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .issueRow(issueRow),
    .inData(inData), .outWrite(outWrite), .outRow(outRow), .outSum(outSum)
  );
endmodule

// File: rtl/row_interleave_acc_chk.sv
module row_interleave_acc_chk (
  input logic clk,
  input logic rstN,
  input logic inEmpty,
  input logic inRead,
  input logic outWrite,
  input logic done
);
  a_r3_no_read_empty: assert property (@(posedge clk) disable iff (!rstN)
    inEmpty |-> !inRead);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outWrite));
  a_r9_no_read_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inRead);
endmodule

bind row_interleave_acc row_interleave_acc_chk u_chk (
  .clk(clk), .rstN(rstN), .inEmpty(inEmpty), .inRead(inRead),
  .outWrite(outWrite), .done(done)
);

// File: tb/row_interleave_acc_bench.sv
`timescale 1ns/1ps
module row_interleave_acc_bench;
  localparam int L = 10, K = 4, W = 32, CW = 16, MAX_ROWS = 64, RW = 6;
  localparam int NT = 12;
  localparam int TABLE_CNT [NT] = '{5, 1, 8, 4, 13, 2, 9, 3, 16, 7, 1, 20};

  logic clk = 0, rstN = 0, start = 0, loadEn = 0, inEmpty = 1;
  logic [RW:0] numRows = 0;
  logic [RW-1:0] loadAddr = 0;
  logic [CW-1:0] loadCount = 0;
  logic [W-1:0] inData = 0;
  logic inRead, outWrite, done;
  logic [RW-1:0] outRow;
  logic [W-1:0] outSum;

  int checks = 0, errors = 0;
  int cnt [MAX_ROWS];
  int n;
  bit stallOn;
  longint stream [4096];
  int slen;
  longint result [MAX_ROWS];
  int wcount [MAX_ROWS];
  int totalWrites, doneCount, doneCyc, lastWriteCyc, firstRow, readEmpty, lateReads;

  always #2.5 clk = ~clk;

  row_interleave_acc #(.L(L), .K(K), .W(W), .CW(CW), .MAX_ROWS(MAX_ROWS)) u_row_interleave_acc (
    .clk(clk), .rstN(rstN), .start(start), .numRows(numRows), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadCount(loadCount), .inEmpty(inEmpty), .inData(inData),
    .inRead(inRead), .outWrite(outWrite), .outRow(outRow), .outSum(outSum), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint val(int r, int p);
    return longint'(r * 8 + p + 1);
  endfunction

  function automatic longint expSum(int r, int c);
    longint p = (c + K - 1) / K;
    return p * longint'(r * 8 + 1) + p * (p - 1) / 2;
  endfunction

  // Software packing of the row-interleaved stream
  task automatic buildStream();
    int remM [L]; int rowM [L]; int passM [L];
    int nextR = 0; bit any;
    slen = 0;
    for (int s = 0; s < L; s++) begin remM[s] = 0; rowM[s] = 0; passM[s] = 0; end
    for (int it = 0; it < 100000; it++) begin
      int s = it % L;
      any = 0;
      for (int j = 0; j < L; j++) if (remM[j] > 0) any = 1;
      if (!any && nextR >= n) break;
      if (remM[s] == 0 && nextR < n) begin
        rowM[s] = nextR; passM[s] = 0; remM[s] = cnt[nextR]; nextR++;
      end
      if (remM[s] > 0) begin
        stream[slen] = val(rowM[s], passM[s]); slen++;
        passM[s]++;
        remM[s] = (remM[s] > K) ? remM[s] - K : 0;
      end
    end
  endtask

  task automatic runMatrix();
    int idx = 0;
    bit emptyNow, seen = 0;
    int extra = 0;
    for (int r = 0; r < n; r++) begin
      @(negedge clk); loadEn = 1; loadAddr = RW'(r); loadCount = CW'(cnt[r]);
    end
    @(negedge clk); loadEn = 0;
    buildStream();
    for (int r = 0; r < MAX_ROWS; r++) begin result[r] = -1; wcount[r] = 0; end
    totalWrites = 0; doneCount = 0; doneCyc = -1; lastWriteCyc = -1;
    firstRow = -1; readEmpty = 0; lateReads = 0;
    inEmpty = 1; start = 1; numRows = (RW+1)'(n);
    @(negedge clk); start = 0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      emptyNow = (idx >= slen) || (stallOn && (cyc % 3 == 1));
      if (seen) emptyNow = 0;            // offer data after done: none may be read
      inEmpty = emptyNow;
      inData = (idx < slen) ? W'(stream[idx]) : '0;
      #1;
      if (inRead && emptyNow) readEmpty++;
      if (seen && inRead) lateReads++;
      if (outWrite) begin
        if (firstRow < 0) firstRow = int'(outRow);
        result[outRow] = longint'(outSum);
        wcount[outRow]++;
        totalWrites++;
        lastWriteCyc = cyc;
      end
      if (done) begin doneCount++; doneCyc = cyc; seen = 1; end
      if (inRead) idx++;
      if (seen) begin extra++; if (extra > 30) break; end
    end
    @(negedge clk); inEmpty = 1;
    chk(seen, "R10 done seen", seen, 1);
    chk(idx == slen, "R2 words consumed", idx, slen);
  endtask

  task automatic checkSums(input string tag);
    for (int r = 0; r < n; r++) begin
      chk(result[r] == expSum(r, cnt[r]), tag, result[r], expSum(r, cnt[r]));
      chk(wcount[r] == 1, "R6 single write per row", wcount[r], 1);
    end
    chk(totalWrites == n, "R8 write count", totalWrites, n);
    chk(doneCount == 1, "R10 done pulses", doneCount, 1);
    chk(doneCyc == lastWriteCyc + 1, "R10 done timing", doneCyc, lastWriteCyc + 1);
    chk(readEmpty == 0, "R3 read while empty", readEmpty, 0);
    chk(lateReads == 0, "R9 read after drain", lateReads, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11: idle after reset even with data offered
    inEmpty = 0; inData = 7;
    repeat (5) begin
      @(negedge clk); #1;
      chk(!outWrite && !done && !inRead, "R11 reset idle", {outWrite, done, inRead}, 0);
    end
    inEmpty = 1;

    // Table walk: more rows than slots, varied counts (R1 R2 R4)
    n = NT; stallOn = 0;
    for (int r = 0; r < NT; r++) cnt[r] = TABLE_CNT[r];
    runMatrix();
    checkSums("R1 R4 row sum");

    // Same matrix with input stalls (R7)
    stallOn = 1;
    runMatrix();
    checkSums("R7 row sum under stalls");

    // Out-of-order completion (R5)
    stallOn = 0; n = 2; cnt[0] = 12; cnt[1] = 2;
    runMatrix();
    checkSums("R5 row sum");
    chk(firstRow == 1, "R5 first written row", firstRow, 1);

    // Few rows, most slots idle, drain (R8 R9)
    n = 3; cnt[0] = 1; cnt[1] = 1; cnt[2] = 4;
    runMatrix();
    checkSums("R8 row sum");

    // Single long row, many feedback passes (R2 R6)
    n = 1; cnt[0] = 37;
    runMatrix();
    checkSums("R2 long row sum");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule